// File: doc/BRIEF.md
# Memory-Mapped Interrupt Aggregator

The block gathers up to 32 level-sensitive interrupt request lines into a single processor interrupt. Each line owns one bit of a status register. The bit is set while its line is high and is cleared when the line falls. Software can also act on the status: it can clear chosen bits by writing ones to them, or it can load the whole register through a separate set port. A per-line enable mask decides which status bits drive the processor output. A read-only view returns the status bits that pass the mask.

All registers sit on a simple 32-bit single-cycle read/write bus with byte offsets. Line `i` is bit `i` of every register. When a peripheral numbers its request `p` in the opposite bit order, it is wired to line `31 - p` at integration. The interrupt output, read data and error flag are all registered.

Top module: `irq_aggregator`

## Requirements
- R1: A synchronous active-high reset clears status, enable, the interrupt output, the read data and the error flag to zero.
- R2: A source line that is high at a clock edge sets its status bit at that edge.
- R3: At the edge after a source line goes from high to low, its status bit is cleared.
- R4: A write to offset 0x00 clears every status bit whose write-data bit is one. Bits with write-data zero keep their value.
- R5: A status bit whose source is high stays set even when a write-one-to-clear or a set-port write targets it in the same cycle.
- R6: A write to offset 0x0C loads the written value into status. This holds for bits whose source is neither high nor falling in that cycle.
- R7: Offset 0x04 is the enable register. A write loads all 32 bits, and a read returns them.
- R8: A read of offset 0x08 returns status AND enable. A write to 0x08 changes neither status nor enable.
- R9: The interrupt output is high exactly when status AND enable is nonzero. It follows a write or a source change at the same clock edge that updates the register.
- R10: Read data appears in the cycle after the access and reflects register contents before that edge. Reads of both 0x00 and 0x0C return the raw status.
- R11: An access to any other offset, including a misaligned one or one at 0x10 and above, reads zero and has no effect on any register. It raises the error flag for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | 32 | Level-sensitive interrupt request lines, line i on bit i |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
Four rules are checked on every cycle:
- the interrupt output always equals the OR of status AND enable;
- a high source always leaves its status bit set at the next edge;
- an enable write lands exactly, and a write to the masked view leaves the enable mask untouched;
- the error flag only follows a bus access.

The bench scenarios cover the rest. These are the falling-edge clear, write-one-to-clear against lines that are low, set-port loading, and the one-cycle read latency with pre-edge data. They also cover the zero read data of unmapped offsets and the return to a clean state after a reset in mid-run.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Word index of each register (byte offset bits [3:2]).
  localparam logic [1:0] WIDX_STAT = 2'd0;
  localparam logic [1:0] WIDX_EN   = 2'd1;
  localparam logic [1:0] WIDX_MASK = 2'd2;
  localparam logic [1:0] WIDX_SET  = 2'd3;

  typedef enum logic [2:0] {
    RS_STAT,
    RS_EN,
    RS_MASK,
    RS_SET,
    RS_NONE
  } reg_sel_e;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_sel_e          rsel,
  output logic              wr_clr,
  output logic              wr_set,
  output logic              wr_en,
  output logic              rd,
  output logic              bad
);

  logic aligned;
  logic in_window;
  logic [1:0] widx;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign in_window = ((bus_addr >> 4) == '0);
  assign widx      = bus_addr[3:2];

  always_comb begin
    rsel = RS_NONE;
    if (aligned && in_window) begin
      case (widx)
        WIDX_STAT: rsel = RS_STAT;
        WIDX_EN:   rsel = RS_EN;
        WIDX_MASK: rsel = RS_MASK;
        WIDX_SET:  rsel = RS_SET;
        default:   rsel = RS_NONE;
      endcase
    end
  end

  assign wr_clr = bus_sel && bus_we && (rsel == RS_STAT);
  assign wr_set = bus_sel && bus_we && (rsel == RS_SET);
  assign wr_en  = bus_sel && bus_we && (rsel == RS_EN);
  assign rd     = bus_sel && !bus_we && (rsel != RS_NONE);
  assign bad    = bus_sel && (rsel == RS_NONE);

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src,
  input  logic               wr_clr,
  input  logic               wr_set,
  input  logic [NUM_SRC-1:0] wval,
  output logic [NUM_SRC-1:0] status_q,
  output logic [NUM_SRC-1:0] status_nxt
);

  logic [NUM_SRC-1:0] src_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_d <= '0;
    end else begin
      src_d <= src;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic sw_val;
    logic fell;

    // Software view of the bit: set-port load beats clear.
    always_comb begin
      if (wr_set) begin
        sw_val = wval[i];
      end else if (wr_clr) begin
        sw_val = status_q[i] & ~wval[i];
      end else begin
        sw_val = status_q[i];
      end
    end

    assign fell = src_d[i] & ~src[i];

    // A high line forces the bit; a falling line clears it.
    assign status_nxt[i] = src[i] ? 1'b1 : (fell ? 1'b0 : sw_val);

    always_ff @(posedge clk) begin
      if (rst) begin
        status_q[i] <= 1'b0;
      end else begin
        status_q[i] <= status_nxt[i];
      end
    end
  end

endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wval,
  output logic [NUM_SRC-1:0] enable_q,
  output logic [NUM_SRC-1:0] enable_nxt
);

  assign enable_nxt = wr_en ? wval : enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
    end else begin
      enable_q <= enable_nxt;
    end
  end

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] status_nxt,
  input  logic [NUM_SRC-1:0] enable_nxt,
  output logic               irq_q
);

  logic any_pending;

  assign any_pending = |(status_nxt & enable_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= any_pending;
    end
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lines,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               irq_out
);

  reg_sel_e           rsel;
  logic               wr_clr;
  logic               wr_set;
  logic               wr_en;
  logic               rd;
  logic               bad;
  logic [NUM_SRC-1:0] wval;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] status_nxt;
  logic [NUM_SRC-1:0] enable_q;
  logic [NUM_SRC-1:0] enable_nxt;
  logic [DATA_W-1:0]  rd_val;

  assign wval = bus_wdata[NUM_SRC-1:0];

  irq_reg_decode #(.ADDR_W(ADDR_W)) decode_i (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .rsel     (rsel),
    .wr_clr   (wr_clr),
    .wr_set   (wr_set),
    .wr_en    (wr_en),
    .rd       (rd),
    .bad      (bad)
  );

  irq_status_bank #(.NUM_SRC(NUM_SRC)) status_i (
    .clk        (clk),
    .rst        (rst),
    .src        (src_lines),
    .wr_clr     (wr_clr),
    .wr_set     (wr_set),
    .wval       (wval),
    .status_q   (status_q),
    .status_nxt (status_nxt)
  );

  irq_enable_reg #(.NUM_SRC(NUM_SRC)) enable_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wval       (wval),
    .enable_q   (enable_q),
    .enable_nxt (enable_nxt)
  );

  irq_out_stage #(.NUM_SRC(NUM_SRC)) out_i (
    .clk        (clk),
    .rst        (rst),
    .status_nxt (status_nxt),
    .enable_nxt (enable_nxt),
    .irq_q      (irq_out)
  );

  // Read mux over pre-edge register contents.
  always_comb begin
    case (rsel)
      RS_STAT: rd_val = DATA_W'(status_q);
      RS_SET:  rd_val = DATA_W'(status_q);
      RS_EN:   rd_val = DATA_W'(enable_q);
      RS_MASK: rd_val = DATA_W'(status_q & enable_q);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_rdata <= rd ? rd_val : '0;
      bus_err   <= bad;
    end
  end

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic               irq,
  input logic               sel,
  input logic               we,
  input logic [ADDR_W-1:0]  addr,
  input logic [DATA_W-1:0]  wdata,
  input logic               err
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8);

  // R9
  irq_matches_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(status & enable)));

  // R5
  src_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (src != '0) |=> ((status & $past(src)) == $past(src)));

  // R7
  en_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && we && addr == A_EN) |=> (enable == $past(wdata[NUM_SRC-1:0])));

  // R8
  mask_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && we && addr == A_MASK) |=> $stable(enable));

  // R11
  err_needs_access_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(sel));

endmodule

bind irq_aggregator irq_aggregator_chk #(
  .NUM_SRC(NUM_SRC),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk    (clk),
  .rst    (rst),
  .src    (src_lines),
  .status (status_q),
  .enable (enable_q),
  .irq    (irq_out),
  .sel    (bus_sel),
  .we     (bus_we),
  .addr   (bus_addr),
  .wdata  (bus_wdata),
  .err    (bus_err)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb_top;

  localparam int NS = 32;
  localparam int DW = 32;
  localparam int AW = 5;

  localparam logic [1:0] OP_IDLE = 2'd0;
  localparam logic [1:0] OP_WR   = 2'd1;
  localparam logic [1:0] OP_RD   = 2'd2;

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [NS-1:0] src;
    logic [DW-1:0] exp_rd;
    logic          exp_irq;
    logic          exp_err;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{OP_WR,   5'h04, 32'h0000_00FF, 32'h0000_0000, 32'h0, 1'b0, 1'b0}, // R7 write enable
    '{OP_RD,   5'h04, 32'h0,         32'h0000_0001, 32'h0000_00FF, 1'b1, 1'b0}, // R2 rise, R7 read
    '{OP_RD,   5'h00, 32'h0,         32'h0000_0001, 32'h0000_0001, 1'b1, 1'b0}, // R10 raw status
    '{OP_WR,   5'h00, 32'h0000_0001, 32'h0000_0001, 32'h0, 1'b1, 1'b0}, // R5 source wins
    '{OP_IDLE, 5'h00, 32'h0,         32'h0000_0000, 32'h0, 1'b0, 1'b0}, // R3 fall clears
    '{OP_WR,   5'h0C, 32'h8000_0010, 32'h0000_0000, 32'h0, 1'b1, 1'b0}, // R6 set load
    '{OP_RD,   5'h08, 32'h0,         32'h0000_0000, 32'h0000_0010, 1'b1, 1'b0}, // R8 masked
    '{OP_WR,   5'h00, 32'h0000_0010, 32'h0000_0000, 32'h0, 1'b0, 1'b0}, // R4 w1c
    '{OP_RD,   5'h00, 32'h0,         32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0}, // R4 others kept
    '{OP_WR,   5'h08, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0, 1'b0, 1'b0}, // R8 write ignored
    '{OP_RD,   5'h04, 32'h0,         32'h0000_0000, 32'h0000_00FF, 1'b0, 1'b0}, // R8 enable kept
    '{OP_RD,   5'h00, 32'h0,         32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0}, // R8 status kept
    '{OP_WR,   5'h04, 32'h8000_0000, 32'h0000_0000, 32'h0, 1'b1, 1'b0}, // R9 enable raises irq
    '{OP_RD,   5'h0C, 32'h0,         32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0}, // R10 set-port read
    '{OP_RD,   5'h10, 32'h0,         32'h0000_0000, 32'h0, 1'b1, 1'b1}, // R11 out of window
    '{OP_WR,   5'h06, 32'h0000_0000, 32'h0000_0000, 32'h0, 1'b1, 1'b1}, // R11 misaligned write
    '{OP_RD,   5'h04, 32'h0,         32'h0000_0000, 32'h8000_0000, 1'b1, 1'b0}, // R11 no effect
    '{OP_WR,   5'h00, 32'h8000_0000, 32'h0000_0000, 32'h0, 1'b0, 1'b0}  // R4 last bit
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_lines = '0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  irq_aggregator #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .src_lines (src_lines),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .irq_out   (irq_out)
  );

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive at negedge, let one posedge pass, sample shortly after it.
  task automatic cycle(input logic [1:0] op, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [NS-1:0] s);
    @(negedge clk);
    bus_sel   = (op != OP_IDLE);
    bus_we    = (op == OP_WR);
    bus_addr  = a;
    bus_wdata = d;
    src_lines = s;
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 irq", DW'(irq_out), 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 err", DW'(bus_err), 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      cycle(VECS[k].op, VECS[k].addr, VECS[k].wdata, VECS[k].src);
      check($sformatf("R9 irq vec%0d", k), DW'(irq_out), DW'(VECS[k].exp_irq));
      check($sformatf("R11 err vec%0d", k), DW'(bus_err), DW'(VECS[k].exp_err));
      if (VECS[k].op == OP_RD)
        check($sformatf("R10 rdata vec%0d", k), bus_rdata, VECS[k].exp_rd);
    end

    // R9 timing: a line rise is not visible before the edge.
    cycle(OP_WR, 5'h04, 32'h0000_0100, '0);
    @(negedge clk);
    bus_sel = 1'b0;
    src_lines = 32'h0000_0100;
    #4;
    check("R9 before edge", DW'(irq_out), 32'h0);
    @(posedge clk);
    #1;
    check("R9 after edge", DW'(irq_out), 32'h1);

    // R6/R5: set-port write of zero cannot clear a high line's bit.
    cycle(OP_WR, 5'h0C, 32'h0000_0003, 32'h0000_0100);
    cycle(OP_RD, 5'h00, 32'h0, 32'h0000_0100);
    check("R6 set with held line", bus_rdata, 32'h0000_0103);
    cycle(OP_WR, 5'h0C, 32'h0000_0000, 32'h0000_0100);
    cycle(OP_RD, 5'h00, 32'h0, 32'h0000_0100);
    check("R5 set port vs line", bus_rdata, 32'h0000_0100);

    // R3 with no enabled bit left after fall
    cycle(OP_IDLE, 5'h00, 32'h0, 32'h0);
    check("R3 fall drops irq", DW'(irq_out), 32'h0);

    // R1 reset in mid-run
    cycle(OP_WR, 5'h0C, 32'hFFFF_FFFF, 32'h0);
    check("R6 full load irq", DW'(irq_out), 32'h1);
    @(negedge clk);
    rst = 1'b1;
    bus_sel = 1'b1;
    bus_we = 1'b0;
    bus_addr = 5'h10;
    @(posedge clk);
    #1;
    check("R1 irq cleared", DW'(irq_out), 32'h0);
    check("R1 err cleared", DW'(bus_err), 32'h0);
    @(negedge clk);
    rst = 1'b0;
    bus_sel = 1'b0;
    cycle(OP_RD, 5'h00, 32'h0, 32'h0);
    check("R1 status cleared", bus_rdata, 32'h0);
    cycle(OP_RD, 5'h04, 32'h0, 32'h0);
    check("R1 enable cleared", bus_rdata, 32'h0);
    cycle(OP_IDLE, 5'h00, 32'h0, 32'h0);
    check("R10 rdata idle", bus_rdata, 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule